// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire SMBus-style bus. It gives a host read and write access to a small bank of eight-bit configuration registers, such as the enable bits of individual clock output buffers. The block runs on a fast system clock and oversamples the bus clock and data lines through a synchronizer. It pulls the data line low through an output-enable, so the pad is open-drain. The whole register bank is presented as one parallel output vector. Each register comes out of reset holding a parameterised default, so a system that never talks to the block still gets useful settings.

The host picks the kind of access in the command byte. The top bit selects either a single indexed byte or a block. Two chip-select bits must be zero. The low five bits give the byte offset. A block write carries a byte count, and its data lands in the bank from register 0 upward. A block read first returns the number of implemented registers, then the registers in ascending order. Any read continues for as long as the host acknowledges each byte.

Top module: `smb_cfg_slave`

## Requirements
- R1: The block acknowledges only the seven-bit address DEV_ADDR (default 1101001, so the address byte is D2h for a write and D3h for a read). A transaction with any other address receives no acknowledge on any byte and changes no register.
- R2: After reset, byte i of `cfg_out` (bits 8i+7 down to 8i) equals byte i of REG_INIT.
- R3: In a byte write, the command byte has bit 7 = 1 and the offset in bits 4:0, and exactly one data byte follows. That data byte is written to the register at that offset. Further data bytes in the same transaction are acknowledged and discarded.
- R4: In a byte read, the host sends the write address, a command with bit 7 = 1, a repeated start, and then the read address. The block returns the register at the offset, most significant bit first. Each further byte the host acknowledges comes from the next offset up.
- R5: In a block write, the command byte has bit 7 = 0, and a count byte follows the command. Data bytes are written to registers 0, 1, 2 and onward in order. Bytes beyond the count are acknowledged and discarded. A host may stop after any whole byte.
- R6: In a block read, the host sends a command with bit 7 = 0, then a repeated start and the read address. The block first returns NREG, then registers 0, 1 and onward. It stops driving after a byte that the host does not acknowledge.
- R7: A command byte whose bits 6:5 are not 00 is not acknowledged. No later byte of that transaction is acknowledged or written, up to the next start.
- R8: A write to an offset at or above NREG is acknowledged and changes no register. A read of such an offset returns 00h.
- R9: A start or stop that arrives before the eighth bit of a byte abandons that byte, and no register is written from it. After a start, the next byte is taken as an address.
- R10: The block only ever pulls the data line low. Its output-enable turns on only while the synchronized clock line is low.
- R11: A read address that no accepted command has preceded since the last stop is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| cfg_out | output | NREG*8 | Register bank, register i in bits 8i+7:8i |

## Verification
The bench builds the block with eight registers and a default vector in which every byte is different. This lets the reset check and every read tell one register from another. With eight registers, offsets 8 and 9 fall outside the bank, so the discarded-write and zero-read paths are reached. Block counts of nine and reads of ten bytes run past the last register. The synchronizer is kept at two stages, and the bus bit period is sixteen system clocks, which keeps start, stop and mid-byte aborts within a short run.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_ACK_WAIT,
        ST_ACK,
        ST_RDATA,
        ST_RD_END,
        ST_RACK,
        ST_IGNORE
    } smb_state_e;

    typedef struct packed {
        logic       single;
        logic [1:0] csel;
        logic [4:0] offset;
    } smb_cmd_t;

    function automatic smb_cmd_t decode_cmd(input logic [7:0] b);
        smb_cmd_t c;
        c.single = b[7];
        c.csel   = b[6:5];
        c.offset = b[4:0];
        return c;
    endfunction

    // Saturating pointer step, so long reads never wrap back into the bank.
    function automatic logic [7:0] ptr_next(input logic [7:0] p);
        return (p == 8'hFF) ? p : p + 8'd1;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_pipe[STAGES-1];
            sda_p <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
    parameter int                  NREG     = 8,
    parameter logic [NREG*8-1:0]   REG_INIT = {NREG{8'hFF}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] bank [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    bank[g] <= REG_INIT[8*g +: 8];
                else if (wr_en && wr_idx == 8'(g))
                    bank[g] <= wr_data;
            end
            assign regs_flat[8*g +: 8] = bank[g];

            // R3 / R5: a write aimed at this register lands there on the next cycle
            assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_idx == 8'(g)) |=> (regs_flat[8*g +: 8] == $past(wr_data)));
        end
    endgenerate

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == 8'(i)) rd_data = bank[i];
    end

    // R8: a write beyond the bank leaves every register unchanged
    assert_oob_discard_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= 8'(NREG)) |=> $stable(regs_flat));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int                NREG        = 8,
    parameter logic [6:0]        DEV_ADDR    = 7'h69,
    parameter logic [NREG*8-1:0] REG_INIT    = {NREG{8'hFF}},
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_out
);
    localparam logic [7:0] COUNT_BYTE = 8'(NREG);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    smb_state_e state, ack_next;
    logic       ack_drive;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic [7:0] ptr;
    logic [7:0] remaining;
    logic [4:0] cmd_off;
    logic       single_mode, armed, count_first, rack_nack;

    logic [7:0] rx_byte, rd_data, next_tx;
    smb_cmd_t   cmd_dec;
    logic       last_rx, wr_en, load_tx;

    assign rx_byte = {rx_sr, sda_s};
    assign cmd_dec = decode_cmd(rx_byte);
    assign last_rx = scl_rise && (bit_cnt == 3'd7);
    assign wr_en   = (state == ST_WDATA) && last_rx && (remaining != 8'd0);
    assign next_tx = count_first ? COUNT_BYTE : rd_data;
    assign load_tx = scl_fall && (((state == ST_ACK) && (ack_next == ST_RDATA)) ||
                                  ((state == ST_RACK) && !rack_nack));

    smb_regbank #(.NREG(NREG), .REG_INIT(REG_INIT)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(ptr), .wr_data(rx_byte),
        .rd_idx(ptr), .rd_data(rd_data), .regs_flat(cfg_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ack_next    <= ST_IGNORE;
            ack_drive   <= 1'b0;
            bit_cnt     <= 3'd0;
            rx_sr       <= 7'd0;
            tx_sr       <= 8'hFF;
            ptr         <= 8'd0;
            remaining   <= 8'd0;
            cmd_off     <= 5'd0;
            single_mode <= 1'b0;
            armed       <= 1'b0;
            count_first <= 1'b0;
            rack_nack   <= 1'b1;
        end else if (bus_stop) begin
            state <= ST_IDLE;
            armed <= 1'b0;
        end else if (bus_start) begin
            state   <= ST_ADDR;
            bit_cnt <= 3'd0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sr   <= {rx_sr[5:0], sda_s};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            state     <= ST_ACK_WAIT;
                            ack_drive <= 1'b1;
                            if (state == ST_ADDR) begin
                                if (rx_byte[7:1] != DEV_ADDR) begin
                                    state <= ST_IGNORE;
                                end else if (!rx_byte[0]) begin
                                    ack_next <= ST_CMD;
                                    armed    <= 1'b0;
                                end else if (armed) begin
                                    ack_next    <= ST_RDATA;
                                    count_first <= !single_mode;
                                    ptr         <= single_mode ? {3'b000, cmd_off} : 8'd0;
                                end else begin
                                    ack_drive <= 1'b0;
                                    ack_next  <= ST_IGNORE;
                                end
                            end else if (state == ST_CMD) begin
                                if (cmd_dec.csel != 2'b00) begin
                                    ack_drive <= 1'b0;
                                    ack_next  <= ST_IGNORE;
                                end else begin
                                    single_mode <= cmd_dec.single;
                                    cmd_off     <= cmd_dec.offset;
                                    ptr         <= cmd_dec.single ? {3'b000, cmd_dec.offset} : 8'd0;
                                    remaining   <= 8'd1;
                                    armed       <= 1'b1;
                                    ack_next    <= cmd_dec.single ? ST_WDATA : ST_COUNT;
                                end
                            end else if (state == ST_COUNT) begin
                                remaining <= rx_byte;
                                ptr       <= 8'd0;
                                ack_next  <= ST_WDATA;
                            end else begin
                                ptr <= ptr_next(ptr);
                                if (remaining != 8'd0) remaining <= remaining - 8'd1;
                                ack_next <= ST_WDATA;
                            end
                        end
                    end
                end
                ST_ACK_WAIT: if (scl_fall) state <= ST_ACK;
                ST_ACK: begin
                    if (scl_fall) begin
                        state   <= ack_next;
                        bit_cnt <= 3'd0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx_sr <= {tx_sr[6:0], 1'b1};
                    end else if (scl_rise) begin
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) state <= ST_RD_END;
                    end
                end
                ST_RD_END: if (scl_fall) state <= ST_RACK;
                ST_RACK: begin
                    if (scl_rise) begin
                        rack_nack <= sda_s;
                    end else if (scl_fall) begin
                        state   <= rack_nack ? ST_IGNORE : ST_RDATA;
                        bit_cnt <= 3'd0;
                    end
                end
                default: ;
            endcase
            if (load_tx) begin
                tx_sr <= next_tx;
                if (count_first) count_first <= 1'b0;
                else             ptr <= ptr_next(ptr);
            end
        end
    end

    assign sda_oe = ((state == ST_ACK) && ack_drive) ||
                    (((state == ST_RDATA) || (state == ST_RD_END)) && !tx_sr[7]);

    // R10: the pull-down is only switched on while the clock line is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R9: a start always returns the byte engine to address reception
    assert_start_to_addr_R9: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> (state == ST_ADDR));

    // R9: a stop ends the transaction and releases the line
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> ((state == ST_IDLE) && !sda_oe));

    // R1: an address that does not match sends the engine to the ignore state
    assert_addr_mismatch_R1: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ADDR) && last_rx && (rx_byte[7:1] != DEV_ADDR)) |=> (state == ST_IGNORE));

    // R7: an acknowledge slot that leads into ignore never pulls the line
    assert_nack_slot_R7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ACK) && (ack_next == ST_IGNORE)) |-> !sda_oe);
endmodule

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;
    localparam int         NR   = 8;
    localparam logic [63:0] INIT = 64'hA7_96_85_74_63_52_41_30;
    localparam int         Q    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [63:0] cfg_out;
    wire         sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    smb_cfg_slave #(.NREG(NR), .DEV_ADDR(7'h69), .REG_INIT(INIT), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .cfg_out(cfg_out)
    );

    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] mdl [NR];

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] mdl_cfg();
        logic [63:0] v;
        for (int i = 0; i < NR; i++) v[8*i +: 8] = mdl[i];
        return v;
    endfunction

    function automatic logic [7:0] mdl_rd(input int idx);
        return (idx < NR) ? mdl[idx] : 8'h00;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic m_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_send(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit(d[i]);
        m_rbit(b);
        ack = !b;
    endtask

    task automatic m_recv(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_bit(!give_ack);
    endtask

    task automatic byte_write(input logic [4:0] off, input logic [7:0] d, input bit extra);
        logic ack;
        m_start();
        m_send(8'hD2, ack); chk("R1", "write address ack", ack, 1);
        m_send({3'b100, off}, ack); chk("R3", "byte command ack", ack, 1);
        m_send(d, ack); chk(off < NR ? "R3" : "R8", "data ack", ack, 1);
        if (extra) begin
            m_send(~d, ack); chk("R3", "extra byte ack", ack, 1);
        end
        m_stop();
        if (off < NR) mdl[off] = d;
        chk(off < NR ? "R3" : "R8", "bank after byte write", cfg_out, mdl_cfg());
    endtask

    task automatic byte_read(input logic [4:0] off, input int n);
        logic ack; logic [7:0] d;
        m_start();
        m_send(8'hD2, ack); chk("R1", "write address ack", ack, 1);
        m_send({3'b100, off}, ack); chk("R4", "byte command ack", ack, 1);
        m_rstart();
        m_send(8'hD3, ack); chk("R4", "read address ack", ack, 1);
        for (int j = 0; j < n; j++) begin
            m_recv(j != n - 1, d);
            chk((off + j) < NR ? "R4" : "R8", "byte read data", d, mdl_rd(off + j));
        end
        m_stop();
    endtask

    task automatic block_write(input int count, input int nsend);
        logic ack; logic [7:0] d;
        m_start();
        m_send(8'hD2, ack); chk("R1", "write address ack", ack, 1);
        m_send(8'h00, ack); chk("R5", "block command ack", ack, 1);
        m_send(8'(count), ack); chk("R5", "count ack", ack, 1);
        for (int k = 0; k < nsend; k++) begin
            d = 8'($urandom);
            m_send(d, ack); chk("R5", "block data ack", ack, 1);
            if (k < count && k < NR) mdl[k] = d;
        end
        m_stop();
        chk("R5", "bank after block write", cfg_out, mdl_cfg());
    endtask

    task automatic block_read(input int n);
        logic ack; logic [7:0] d;
        m_start();
        m_send(8'hD2, ack); chk("R1", "write address ack", ack, 1);
        m_send(8'h00, ack); chk("R6", "block command ack", ack, 1);
        m_rstart();
        m_send(8'hD3, ack); chk("R6", "read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            m_recv(k != n - 1, d);
            chk("R6", "block read byte", d, (k == 0) ? 8'(NR) : mdl_rd(k - 1));
        end
        repeat (4) @(negedge clk);
        chk("R6", "line released after host nack", sda_oe, 0);
        m_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) mdl[i] = INIT[8*i +: 8];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2", "reset defaults", cfg_out, INIT);
        chk("R10", "line released after reset", sda_oe, 0);

        // R1: wrong address, nothing acknowledged, nothing written
        m_start();
        m_send(8'hD4, ack); chk("R1", "foreign address nack", ack, 0);
        m_send(8'h81, ack); chk("R1", "byte after foreign address nack", ack, 0);
        m_send(8'h00, ack); chk("R1", "data after foreign address nack", ack, 0);
        m_stop();
        chk("R1", "bank untouched by foreign address", cfg_out, mdl_cfg());

        // R7: chip select not zero
        m_start();
        m_send(8'hD2, ack); chk("R1", "write address ack", ack, 1);
        m_send(8'hA2, ack); chk("R7", "bad chip select nack", ack, 0);
        m_send(8'h5C, ack); chk("R7", "data after bad chip select nack", ack, 0);
        m_stop();
        chk("R7", "bank untouched by bad chip select", cfg_out, mdl_cfg());

        // R11: read address with no command in this transaction
        m_start();
        m_send(8'hD3, ack); chk("R11", "unarmed read nack", ack, 0);
        m_stop();

        // R3 with a trailing extra byte, R8 out of range
        byte_write(5'd2, 8'hC3, 1'b1);
        byte_write(5'd9, 8'h3C, 1'b0);
        byte_read(5'd2, 1);
        byte_read(5'd9, 1);
        byte_read(5'd6, 3);

        // R9: stop in the middle of a data byte
        m_start();
        m_send(8'hD2, ack);
        m_send(8'h83, ack);
        for (int i = 0; i < 4; i++) m_bit(1'b0);
        m_stop();
        chk("R9", "stop mid byte leaves bank", cfg_out, mdl_cfg());

        // R9: start in the middle of a data byte, then a full write
        m_start();
        m_send(8'hD2, ack);
        m_send(8'h83, ack);
        for (int i = 0; i < 5; i++) m_bit(1'b1);
        m_rstart();
        m_send(8'hD2, ack); chk("R9", "address after mid byte start", ack, 1);
        m_send(8'h84, ack);
        m_send(8'h5A, ack);
        m_stop();
        mdl[4] = 8'h5A;
        chk("R9", "only the completed write lands", cfg_out, mdl_cfg());

        // R5 / R6 corners: host stops early, count past bank, read past end
        block_write(6, 2);
        block_write(9, 9);
        block_write(2, 4);
        block_read(10);

        // constrained random mix
        for (int t = 0; t < 30; t++) begin
            int op, c;
            op = $urandom_range(0, 3);
            case (op)
                0: byte_write(5'($urandom_range(0, 9)), 8'($urandom), 1'($urandom_range(0, 1)));
                1: byte_read(5'($urandom_range(0, 9)), $urandom_range(1, 3));
                2: begin
                    c = $urandom_range(1, 9);
                    block_write(c, $urandom_range(1, c + 1));
                end
                default: block_read($urandom_range(1, 10));
            endcase
        end

        chk("R2", "final bank matches model", cfg_out, mdl_cfg());
        d = 8'h00;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail + int'(d));
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule